// File: doc/BRIEF.md
# Compare-Reset 16-bit Timer

A 16-bit up-counter peripheral that sits behind a byte-wide register port. Each time the counter is advanced it goes up by one. The advance signal comes from the internal clock or from rising edges of an external pulse input, and either source passes through a divider of 1, 2, 4 or 8. The external input is first passed through a synchronizer.

When the counter wraps it sets a sticky overflow flag. A separate enable bit gates that flag onto the interrupt line. A 16-bit compare value from a neighbouring unit is checked against the count. On a match the block emits a one-cycle trigger, and the next advance clears the counter instead of incrementing it, so the compare value sets the period.

Software reads and writes the 16-bit count one byte at a time. Reading the low byte captures the high byte into a holding register. Writing the high byte only buffers it, and the full 16 bits are loaded together with the next low-byte write.

Top module: `cmp_timer16`

## Requirements
- R1: Each advance increments the count by one, and 0xFFFF goes to 0x0000. Address map: 0 = count low, 1 = count high, 2 = control, 3 = status.
- R2: Control bits 4:3 select the divider: code 0 gives /1, code 1 gives /2, code 2 gives /4 and code 3 gives /8. The counter advances on every N-th source event while control bit 0 (run) is set.
- R3: A wrap sets status bit 0 (overflow flag). The flag stays set until a status write with bit 0 at zero clears it. If a wrap and such a write happen in the same cycle, the wrap wins.
- R4: irq_o is high exactly when the overflow flag and status bit 1 (interrupt enable) are both set.
- R5: While run is set and cmp_en_i is high, a count equal to cmp_val_i gives a single-cycle pulse on trig_o. The next advance then loads 0x0000 in place of the increment.
- R6: A clear caused by a compare match never sets the overflow flag, even when the matched value is 0xFFFF.
- R7: A low-byte write that lands in the same cycle as a compare clear loads the written value, and the clear is dropped.
- R8: When control bit 1 selects the external source and control bit 2 (sync) is zero, no trigger is produced and no compare clear takes place.
- R9: The external input is synchronized and edge-detected. Each rising edge counts as one source event, no matter how long the input stays high.
- R10: A low-byte read captures the high count byte, and address 1 reads back that captured byte. A high-byte write alone leaves the count unchanged. A low-byte write loads {buffered high, written low} and clears the divider.
- R11: After reset the control register, status register, count and trig_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ext_clk_i | input | 1 | External count pulse input |
| cmp_en_i | input | 1 | Compare trigger mode enable |
| cmp_val_i | input | 16 | Compare value (period) |
| trig_o | output | 1 | Compare trigger pulse |
| irq_o | output | 1 | Gated overflow interrupt |

## Verification
The counting path is driven with a table of divider codes and event counts. The event counts are picked so that a divider off by one position, or a divider that fires early, lands on a different final count. External pulses are applied both as short square waves and as one long high level, which shows whether edge detection is used rather than level counting. Compare tests start near 0xFFFF and at small values with a known period. A low-byte write is timed onto the exact clear cycle, and the run separates a clear from a wrap through the overflow flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_STAT = 2'd3
  } tmr_addr_e;

  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_EXT  = 1;
  localparam int unsigned CTL_SYNC = 2;
  localparam int unsigned CTL_PS_LSB = 3;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [SYNC_N:0] stg_q;

  for (genvar i = 0; i <= SYNC_N; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= 1'b0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign rise_o = stg_q[SYNC_N-1] & ~stg_q[SYNC_N];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic            ev_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int unsigned CW = (1 << PS_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = (CW'(1) << sel_i) - CW'(1);
  assign tick_o = en_i & ev_i & ~clr_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i && ev_i) cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
  import tmr_pkg::*;
#(
  parameter int unsigned PS_W   = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              ext_clk_i,
  input  logic              cmp_en_i,
  input  logic [CNT_W-1:0]  cmp_val_i,
  output logic              trig_o,
  output logic              irq_o
);
  localparam int unsigned CTL_W = CTL_PS_LSB + PS_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CTL_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]  count_q;
  logic [BYTE_W-1:0] hi_buf_q, hold_q;
  logic              flag_q, ien_q, match_q;

  logic ctl_run, ctl_ext, ctl_sync;
  logic wr_lo, wr_hi, wr_ctl, wr_stat;
  logic ext_rise, src_ev, tick, mode_ok, match, ovf;

  assign ctl_run  = ctrl_q[CTL_RUN];
  assign ctl_ext  = ctrl_q[CTL_EXT];
  assign ctl_sync = ctrl_q[CTL_SYNC];

  assign wr_lo   = wr_en_i && (addr_i == ADDR_LO);
  assign wr_hi   = wr_en_i && (addr_i == ADDR_HI);
  assign wr_ctl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);

  tmr_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_clk_i),
    .rise_o (ext_rise)
  );

  assign src_ev = ctl_ext ? ext_rise : 1'b1;

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl_run),
    .clr_i  (wr_lo),
    .ev_i   (src_ev),
    .sel_i  (ctrl_q[CTL_PS_LSB +: PS_W]),
    .tick_o (tick)
  );

  // compare clear only valid for internal or synchronized external source
  assign mode_ok = !ctl_ext || ctl_sync;
  assign match   = ctl_run && cmp_en_i && mode_ok && (count_q == cmp_val_i);
  assign trig_o  = match && !match_q;
  assign ovf     = tick && !wr_lo && !match && (count_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      ctrl_q   <= '0;
      hi_buf_q <= '0;
      hold_q   <= '0;
      match_q  <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      match_q <= match;
      if (wr_lo)     count_q <= {hi_buf_q, wdata_i};
      else if (tick) count_q <= match ? '0 : count_q + CNT_W'(1);
      if (wr_hi)  hi_buf_q <= wdata_i;
      if (wr_ctl) ctrl_q   <= wdata_i[CTL_W-1:0];
      if (wr_stat) ien_q   <= wdata_i[1];
      if (rd_en_i && addr_i == ADDR_LO) hold_q <= count_q[CNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (ovf)                    flag_q <= 1'b1;
    else if (wr_stat && !wdata_i[0]) flag_q <= 1'b0;
  end

  assign irq_o = flag_q & ien_q;

  always_comb begin
    unique case (addr_i)
      ADDR_LO:   rdata_o = count_q[BYTE_W-1:0];
      ADDR_HI:   rdata_o = hold_q;
      ADDR_CTRL: rdata_o = BYTE_W'(ctrl_q);
      default:   rdata_o = {{(BYTE_W-2){1'b0}}, ien_q, flag_q};
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              match,
  input logic              wr_lo,
  input logic              wr_stat,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] hi_buf_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              flag_q,
  input logic              ien_q,
  input logic              ctl_ext,
  input logic              ctl_sync,
  input logic              trig_o,
  input logic              irq_o
);
  a_r1_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_lo && !match) |=> (count_q == $past(count_q) + CNT_W'(1)));

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_stat && !wdata_i[0])) |=> flag_q);

  a_r4_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q && flag_q));

  a_r5_trig_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && match && !wr_lo && !flag_q) |=> (!flag_q && count_q == '0));

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (count_q == {$past(hi_buf_q), $past(wdata_i)}));

  a_r8_async_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !(ctl_ext && !ctl_sync));
endmodule

bind cmp_timer16 tmr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .match    (match),
  .wr_lo    (wr_lo),
  .wr_stat  (wr_stat),
  .wdata_i  (wdata_i),
  .hi_buf_q (hi_buf_q),
  .count_q  (count_q),
  .flag_q   (flag_q),
  .ien_q    (ien_q),
  .ctl_ext  (ctl_ext),
  .ctl_sync (ctl_sync),
  .trig_o   (trig_o),
  .irq_o    (irq_o)
);

// File: tb/tb_cmp_timer16.sv
module tb_cmp_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ext_clk = 1'b0;
  logic        cmp_en = 1'b0;
  logic [15:0] cmp_val = '0;
  logic        trig, irq;

  int n_run = 0, n_fail = 0, trig_cnt = 0;
  logic [15:0] v;
  logic [7:0]  b;

  always #10 clk = ~clk;

  cmp_timer16 dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext_clk), .cmp_en_i(cmp_en),
    .cmp_val_i(cmp_val), .trig_o(trig), .irq_o(irq)
  );

  always @(negedge clk) if (trig) trig_cnt++;

  // {ps[1:0], events[7:0], expected count[15:0]}
  localparam logic [25:0] VEC [5] = '{
    {2'd0, 8'd10, 16'd10},
    {2'd1, 8'd10, 16'd5},
    {2'd2, 8'd11, 16'd2},
    {2'd3, 8'd16, 16'd2},
    {2'd3, 8'd7,  16'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = (a == 2'd0);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    d = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] d);
    wr(2'd1, d[15:8]);
    wr(2'd0, d[7:0]);
  endtask

  task automatic run(input logic [1:0] ps, input logic ext, input logic sync);
    wr(2'd2, {3'b0, ps, sync, ext, 1'b1});
  endtask

  task automatic stop();
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R11 reset state
    rd(2'd2, b); chk("R11 ctrl", b, 8'h00);
    rd(2'd3, b); chk("R11 status", b, 8'h00);
    rd16(v);     chk("R11 count", v, 16'h0000);
    chk("R11 trig/irq", {trig, irq}, 2'b00);

    // R2 divider table
    for (int i = 0; i < 5; i++) begin
      load(16'h0000);
      run(VEC[i][25:24], 1'b0, 1'b0);
      idle(int'(VEC[i][23:16]) - 1);
      stop();
      rd16(v);
      chk($sformatf("R2 vec%0d", i), v, VEC[i][15:0]);
    end

    // R1/R3 wrap sets flag
    load(16'hFFFE);
    run(2'd0, 1'b0, 1'b0); idle(1); stop();
    rd16(v);     chk("R1 wrap", v, 16'h0000);
    rd(2'd3, b); chk("R3 flag set", b, 8'h01);
    chk("R4 irq masked", irq, 1'b0);
    wr(2'd3, 8'h03);
    #1 chk("R4 irq enabled", irq, 1'b1);
    rd(2'd3, b); chk("R3 flag kept on write-1", b, 8'h03);
    wr(2'd3, 8'h02);
    #1 chk("R4 irq after clear", irq, 1'b0);
    rd(2'd3, b); chk("R3 flag cleared", b, 8'h02);
    wr(2'd3, 8'h00);

    // R10 divider cleared by low-byte write
    load(16'h0000);
    run(2'd3, 1'b0, 1'b0); idle(4);
    wr(2'd0, 8'h00); idle(5); stop();
    rd16(v); chk("R10 divider clear", v, 16'h0000);

    // R5 compare period
    cmp_en = 1'b1; cmp_val = 16'd5;
    load(16'h0000);
    trig_cnt = 0;
    run(2'd0, 1'b0, 1'b0); idle(7); stop();
    rd16(v);     chk("R5 count after period", v, 16'd2);
    chk("R5 one trigger", trig_cnt, 1);
    rd(2'd3, b); chk("R6 no flag small cmp", b, 8'h00);

    // R6 clear at 0xFFFF does not flag
    cmp_val = 16'hFFFF;
    load(16'hFFFE);
    run(2'd0, 1'b0, 1'b0); idle(1); stop();
    rd16(v);     chk("R6 cleared", v, 16'h0000);
    rd(2'd3, b); chk("R6 no overflow", b, 8'h00);

    // R7 write on the clear cycle
    cmp_val = 16'd5;
    load(16'h0003);
    wr(2'd1, 8'h12);
    run(2'd0, 1'b0, 1'b0); idle(2);
    wr(2'd0, 8'h34);
    stop();
    rd16(v); chk("R7 write wins", v, 16'h1235);

    // R8 external unsynchronized: no trigger
    cmp_val = 16'd2;
    load(16'h0002);
    trig_cnt = 0;
    run(2'd0, 1'b1, 1'b0); idle(3); stop();
    chk("R8 no trig async", trig_cnt, 0);
    rd16(v); chk("R8 count held", v, 16'h0002);
    trig_cnt = 0;
    run(2'd0, 1'b1, 1'b1); idle(3); stop();
    chk("R8 trig when synced", trig_cnt, 1);
    cmp_en = 1'b0;

    // R9 external edges
    load(16'h0000);
    run(2'd0, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1'b1; idle(2);
      ext_clk = 1'b0; idle(2);
    end
    idle(4);
    rd16(v); chk("R9 five edges", v, 16'd5);
    ext_clk = 1'b1; idle(8);
    rd16(v); chk("R9 level counted once", v, 16'd6);
    ext_clk = 1'b0;
    stop();

    // R10 hold register and buffered high write
    load(16'h1234);
    rd(2'd0, b);
    load(16'hABCD);
    rd(2'd1, b); chk("R10 hold keeps old high", b, 8'h12);
    wr(2'd1, 8'h77);
    rd16(v); chk("R10 high write buffered", v, 16'hABCD);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule